// File: doc/BRIEF.md
# Hot-Plug Slot Power and Latch Control

This block controls power for one downstream hot-plug slot. It samples four slot-side inputs once per cycle: the retention latch sensor, the electromechanical interlock sense, the power-fault indication and the card-present indication. It drives one slot power-enable output. Software requests power on or off through a write strobe that carries a command value. A separate load strobe sets the power command to a stored default and does not report completion.

The block can force slot power off. This happens when automatic power-off is enabled, the slot declares that it has a latch, and the sampled latch reads open. The forced power-off wins over any software command. A mode input changes how status is reported. With the mode set, the latch status always reads closed and the interlock status bit carries the latch sensor. With the mode clear, each status bit shows its own sensor. When the latch opens while the slot is powered, the block emits a one-cycle pulse towards the event logic.

Top module: `slot_hp_power`

## Requirements
- R1: When `auto_off_en` and `latch_present` are both 1 and the sampled latch reads open (`latch_open_in`=1), `slot_pwr_en` is 0. It falls at the second rising edge after the input opens: one edge samples the input, the next edge updates power.
- R2: The forced power-off of R1 wins over the power command. A write with `pcc_wr_val`=1 (1 = power on) leaves `slot_pwr_en` at 0 while the force holds. If `auto_off_en` or `latch_present` is 0, an open latch has no effect on `slot_pwr_en`.
- R3: When `ilock_mode`=1, `latch_sts` reads 0 whatever the latch input is. When `ilock_mode`=0, `latch_sts` equals the latch input sampled one edge earlier.
- R4: When `ilock_mode`=0, `ilock_sts` equals the interlock input sampled one edge earlier. When `ilock_mode`=1, `ilock_sts` carries the sampled latch sensor.
- R5: `pfault_sts` is not latched. It follows `pfault_in` with one edge of delay, and it falls as soon as the input falls.
- R6: A `cfg_load` strobe sets the power command to `cfg_pwr_val`. `slot_pwr_en` updates on the same edge, and `cmd_done` is never set by the load.
- R7: A `pcc_wr_en` strobe updates `slot_pwr_en` on the edge that captures it. `cmd_done` rises on the following edge and stays 1 until a `cmd_done_clr` strobe. A new completion on the same edge as a clear wins over the clear. A write has priority over a simultaneous load.
- R8: When the sampled latch changes from closed to open while `slot_pwr_en` is 1, `latch_chg` is 1 for exactly one cycle, on the same edge that power falls.
- R9: While `rst_n` is low, `slot_pwr_en`, `cmd_done`, `latch_chg` and all status outputs are 0. After release, the block keeps that state until its inputs change.
- R10: `present_sts` follows `present_in` with one edge of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pcc_wr_en | input | 1 | Software power-command write strobe |
| pcc_wr_val | input | 1 | Written power command, 1 = on |
| cfg_load | input | 1 | Default-load strobe |
| cfg_pwr_val | input | 1 | Default power command, 1 = on |
| cmd_done_clr | input | 1 | Clears cmd_done |
| auto_off_en | input | 1 | Enables power-off on an open latch |
| latch_present | input | 1 | The slot has a latch sensor |
| ilock_mode | input | 1 | Interlock-redirect status mode |
| latch_open_in | input | 1 | Latch sensor, 1 = open |
| ilock_in | input | 1 | Interlock sense |
| pfault_in | input | 1 | Power-fault indication |
| present_in | input | 1 | Card-present indication |
| slot_pwr_en | output | 1 | Slot power enable |
| latch_sts | output | 1 | Latch state status |
| ilock_sts | output | 1 | Interlock status |
| pfault_sts | output | 1 | Power-fault status |
| present_sts | output | 1 | Presence status |
| cmd_done | output | 1 | Command-completed status |
| latch_chg | output | 1 | One-cycle pulse: latch opened while powered |

## Verification
The hardest case to reach is the latch-changed pulse. It needs the slot already powered at the exact edge where the sampled latch turns open. Any earlier open latch with the force enabled would already have removed power. The stimulus powers the slot with the latch closed, then opens it with the force both enabled and disabled. It also issues a power-on write in the same cycle as the opening. Random phases then toggle the latch, the command and the configuration bits with low write rates, so that powered-then-opened sequences occur repeatedly.

// File: rtl/slot_hp_pkg.sv
package slot_hp_pkg;
  typedef struct packed {
    logic latch_open;
    logic ilock;
    logic pfault;
    logic present;
  } slot_sense_t;
endpackage

// File: rtl/slot_rst_sync.sv
module slot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/slot_sense_sample.sv
module slot_sense_sample
  import slot_hp_pkg::*;
#(
  parameter int STAGES = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  slot_sense_t raw,
  output slot_sense_t smp
);
  slot_sense_t stage_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      slot_sense_t d;
      if (g == 0) begin : g_first
        assign d = raw;
      end else begin : g_next
        assign d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= d;
      end
    end
  endgenerate

  assign smp = stage_q[STAGES-1];
endmodule

// File: rtl/slot_pwr_ctrl.sv
module slot_pwr_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_val,
  input  logic load_en,
  input  logic load_val,
  input  logic done_clr,
  input  logic auto_off_en,
  input  logic latch_present,
  input  logic latch_open,
  output logic pwr_en,
  output logic done,
  output logic chg_pulse
);
  logic cmd_q, cmd_d;
  logic pwr_q, pwr_d;
  logic pend_q;
  logic done_q, done_d;
  logic latch_prev_q;
  logic chg_q, chg_d;
  logic force_off;
  logic cmd_ce;

  always_comb begin
    force_off = auto_off_en & latch_present & latch_open;
    cmd_ce    = wr_en | load_en;
    cmd_d     = wr_en ? wr_val : load_val;
    pwr_d     = (cmd_ce ? cmd_d : cmd_q) & ~force_off;
    done_d    = (done_q & ~done_clr) | pend_q;
    chg_d     = latch_open & ~latch_prev_q & pwr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q        <= 1'b0;
      pwr_q        <= 1'b0;
      pend_q       <= 1'b0;
      done_q       <= 1'b0;
      latch_prev_q <= 1'b0;
      chg_q        <= 1'b0;
    end else begin
      if (cmd_ce) cmd_q <= cmd_d;
      pwr_q        <= pwr_d;
      pend_q       <= wr_en;
      done_q       <= done_d;
      latch_prev_q <= latch_open;
      chg_q        <= chg_d;
    end
  end

  assign pwr_en    = pwr_q;
  assign done      = done_q;
  assign chg_pulse = chg_q;
endmodule

// File: rtl/slot_sts_map.sv
module slot_sts_map
  import slot_hp_pkg::*;
(
  input  slot_sense_t smp,
  input  logic        ilock_mode,
  output logic        latch_sts,
  output logic        ilock_sts,
  output logic        pfault_sts,
  output logic        present_sts
);
  always_comb begin
    latch_sts   = ilock_mode ? 1'b0 : smp.latch_open;
    ilock_sts   = ilock_mode ? smp.latch_open : smp.ilock;
    pfault_sts  = smp.pfault;
    present_sts = smp.present;
  end
endmodule

// File: rtl/slot_hp_power.sv
module slot_hp_power
  import slot_hp_pkg::*;
#(
  parameter int RST_STAGES = 2,
  parameter int IN_STAGES  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pcc_wr_en,
  input  logic pcc_wr_val,
  input  logic cfg_load,
  input  logic cfg_pwr_val,
  input  logic cmd_done_clr,
  input  logic auto_off_en,
  input  logic latch_present,
  input  logic ilock_mode,
  input  logic latch_open_in,
  input  logic ilock_in,
  input  logic pfault_in,
  input  logic present_in,
  output logic slot_pwr_en,
  output logic latch_sts,
  output logic ilock_sts,
  output logic pfault_sts,
  output logic present_sts,
  output logic cmd_done,
  output logic latch_chg
);
  logic        rst_int_n;
  slot_sense_t raw_sense;
  slot_sense_t smp_sense;

  assign raw_sense = '{latch_open: latch_open_in, ilock: ilock_in,
                       pfault: pfault_in, present: present_in};

  slot_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  slot_sense_sample #(.STAGES(IN_STAGES)) u_smp (
    .clk(clk), .rst_n(rst_int_n), .raw(raw_sense), .smp(smp_sense)
  );

  slot_pwr_ctrl u_pwr (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(pcc_wr_en), .wr_val(pcc_wr_val),
    .load_en(cfg_load), .load_val(cfg_pwr_val),
    .done_clr(cmd_done_clr),
    .auto_off_en(auto_off_en), .latch_present(latch_present),
    .latch_open(smp_sense.latch_open),
    .pwr_en(slot_pwr_en), .done(cmd_done), .chg_pulse(latch_chg)
  );

  slot_sts_map u_sts (
    .smp(smp_sense), .ilock_mode(ilock_mode),
    .latch_sts(latch_sts), .ilock_sts(ilock_sts),
    .pfault_sts(pfault_sts), .present_sts(present_sts)
  );
endmodule

// File: rtl/slot_hp_power_chk.sv
module slot_hp_power_chk
  import slot_hp_pkg::*;
(
  input logic        clk,
  input logic        rst_int_n,
  input logic        pcc_wr_en,
  input logic        cfg_load,
  input logic        auto_off_en,
  input logic        latch_present,
  input logic        ilock_mode,
  input slot_sense_t smp_sense,
  input logic        slot_pwr_en,
  input logic        latch_sts,
  input logic        ilock_sts,
  input logic        cmd_done,
  input logic        latch_chg
);
  // R1 / R2: an active force always removes power on the next edge
  a_r1_force_off: assert property (@(posedge clk) disable iff (!rst_int_n)
    (auto_off_en && latch_present && smp_sense.latch_open) |=> !slot_pwr_en);

  // R3: redirect mode hides the latch state
  a_r3_latch_hidden: assert property (@(posedge clk) disable iff (!rst_int_n)
    ilock_mode |-> !latch_sts);

  // R4: normal mode shows the sampled interlock
  a_r4_ilock_live: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ilock_mode |-> (ilock_sts == smp_sense.ilock));

  // R6: a load alone never raises completion
  a_r6_load_silent: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cfg_load && !pcc_wr_en && !cmd_done && !$past(pcc_wr_en)) |=> !cmd_done);

  // R7: a write completes two edges later
  a_r7_done_after_write: assert property (@(posedge clk) disable iff (!rst_int_n)
    pcc_wr_en |=> ##1 cmd_done);

  // R8: the latch-changed pulse lasts one cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_int_n)
    latch_chg |=> !latch_chg);
endmodule

bind slot_hp_power slot_hp_power_chk u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .pcc_wr_en(pcc_wr_en), .cfg_load(cfg_load),
  .auto_off_en(auto_off_en), .latch_present(latch_present),
  .ilock_mode(ilock_mode), .smp_sense(smp_sense), .slot_pwr_en(slot_pwr_en),
  .latch_sts(latch_sts), .ilock_sts(ilock_sts), .cmd_done(cmd_done),
  .latch_chg(latch_chg)
);

// File: tb/slot_hp_power_bench.sv
`timescale 1ns/1ps
module slot_hp_power_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic pcc_wr_en, pcc_wr_val, cfg_load, cfg_pwr_val, cmd_done_clr;
  logic auto_off_en, latch_present, ilock_mode;
  logic latch_open_in, ilock_in, pfault_in, present_in;
  logic slot_pwr_en, latch_sts, ilock_sts, pfault_sts, present_sts, cmd_done, latch_chg;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  slot_hp_power u_slot_hp_power (.*);

  // expected-state model built from the requirements
  logic m_latch, m_ilock, m_pf, m_pres, m_latch_prev;
  logic m_cmd, m_pwr, m_pend, m_done, m_chg;

  function automatic logic f_force(logic a, logic p, logic l);
    return a & p & l;
  endfunction

  function automatic logic f_cmd(logic we, logic wv, logic le, logic lv, logic cur);
    return we ? wv : (le ? lv : cur);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_latch, m_ilock, m_pf, m_pres, m_latch_prev} = '0;
      {m_cmd, m_pwr, m_pend, m_done, m_chg} = '0;
    end else begin
      logic nc;
      nc     = f_cmd(pcc_wr_en, pcc_wr_val, cfg_load, cfg_pwr_val, m_cmd);
      m_chg  = m_latch & ~m_latch_prev & m_pwr;
      m_pwr  = nc & ~f_force(auto_off_en, latch_present, m_latch);
      m_cmd  = nc;
      m_done = (m_done & ~cmd_done_clr) | m_pend;
      m_pend = pcc_wr_en;
      m_latch_prev = m_latch;
      m_latch = latch_open_in; m_ilock = ilock_in; m_pf = pfault_in; m_pres = present_in;
    end
  end

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1/R2 slot_pwr_en", slot_pwr_en, m_pwr);
    chk("R3 latch_sts", latch_sts, ilock_mode ? 1'b0 : m_latch);
    chk("R4 ilock_sts", ilock_sts, ilock_mode ? m_latch : m_ilock);
    chk("R5 pfault_sts", pfault_sts, m_pf);
    chk("R10 present_sts", present_sts, m_pres);
    chk("R6/R7 cmd_done", cmd_done, m_done);
    chk("R8 latch_chg", latch_chg, m_chg);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check_all();
    pcc_wr_en = 0; cfg_load = 0; cmd_done_clr = 0;
  endtask

  task automatic wr(logic v);
    pcc_wr_en = 1; pcc_wr_val = v; step();
  endtask

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    rst_n = 0;
    {pcc_wr_en, pcc_wr_val, cfg_load, cfg_pwr_val, cmd_done_clr} = '0;
    {auto_off_en, latch_present, ilock_mode} = '0;
    {latch_open_in, ilock_in, pfault_in, present_in} = '0;
    latch_open_in = 1; pfault_in = 1; present_in = 1; ilock_in = 1;
    repeat (3) @(negedge clk);
    // R9: reset state while inputs are active
    chk("R9 pwr in reset", slot_pwr_en, 0);
    chk("R9 sts in reset", latch_sts | ilock_sts | pfault_sts | present_sts, 0);
    chk("R9 done in reset", cmd_done | latch_chg, 0);
    {latch_open_in, ilock_in, pfault_in, present_in} = '0;
    @(negedge clk); rst_n = 1;
    repeat (4) step();

    // R6: load powers on without completion
    cfg_load = 1; cfg_pwr_val = 1; step();
    step(); step();
    chk("R6 load no done", cmd_done, 0);
    // R7: write off, then done, then clear
    wr(0); step(); step();
    chk("R7 done sticky", cmd_done, 1);
    cmd_done_clr = 1; step();
    chk("R7 done cleared", cmd_done, 0);
    // R8 / R1: powered, latch opens with force on
    auto_off_en = 1; latch_present = 1;
    wr(1); step();
    latch_open_in = 1; step(); step(); step();
    chk("R1 forced off", slot_pwr_en, 0);
    // R2: power-on write while forced
    wr(1); step();
    chk("R2 write overridden", slot_pwr_en, 0);
    // R2: no force without latch capability
    latch_present = 0; step(); step();
    chk("R2 no capability", slot_pwr_en, 1);
    // R8: latch reopen with force off, still powered
    latch_open_in = 0; step(); step();
    latch_open_in = 1; pcc_wr_en = 1; pcc_wr_val = 1; step(); step(); step();
    // R3 / R4: redirect mode
    ilock_mode = 1; ilock_in = 0; step(); step();
    chk("R3 latch hidden", latch_sts, 0);
    chk("R4 latch on ilock", ilock_sts, 1);
    ilock_mode = 0; ilock_in = 1; step(); step();
    // R5: fault follows input both ways
    pfault_in = 1; step(); step();
    pfault_in = 0; step();
    chk("R5 fault not held", pfault_sts, 0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      latch_open_in = ($urandom % 4) == 0;
      ilock_in      = $urandom % 2;
      pfault_in     = $urandom % 2;
      present_in    = $urandom % 2;
      if (($urandom % 16) == 0) auto_off_en   = $urandom % 2;
      if (($urandom % 16) == 0) latch_present = $urandom % 2;
      if (($urandom % 16) == 0) ilock_mode    = $urandom % 2;
      pcc_wr_en    = ($urandom % 6) == 0;
      pcc_wr_val   = ($urandom % 4) != 0;
      cfg_load     = ($urandom % 10) == 0;
      cfg_pwr_val  = $urandom % 2;
      cmd_done_clr = ($urandom % 5) == 0;
      step();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule